// File: doc/BRIEF.md
# Sync-Locked Macrocycle Timer

This block times the repeating macrocycle of a field bus master with a down-counter and keeps it aligned to an external synchronization input. A host programs a cycle length and can restart the timer by raising a start bit in its control word; an edge on the asynchronous sync input also restarts it. Whenever the counter runs down to zero before a sync edge has restarted it, the block treats that as a late or missing sync and lights an out-of-sync indicator long enough to be seen on an LED. A second stretched indicator shows that sync edges are arriving.

Every detected sync edge also advances a pulse counter that the host reads, and can clear, to see how many sync events have occurred. The intended use is to program the length slightly longer than the external sync period. While sync keeps arriving the counter is then always restarted before it reaches zero, and the out-of-sync indicator stays dark.

Top module: `mcyc_sync_timer`

## Requirements
- R1: While the active-low reset is asserted, and right after it, the live count is 0, the pulse count is 0 and both indicators are off.
- R2: The sync input is asynchronous and passes through SYNC_STAGES flip-flops. Each rising edge gives exactly one detection, and a sync input held high gives no further detections. With the default of two stages, an edge set up before clock edge k shows up in the outputs after clock edge k+2.
- R3: Once loaded, the live count drops by one on every clock. In the cycle where it reads 0 it reloads the length, so with no other reload the period is length+1 cycles.
- R4: The control word carries the start request in bit CNT_W (bit 31 by default) and the length in bits CNT_W-1:0. A rising edge of the start bit, or a detected sync edge, loads the length into the count on the next clock. A start bit held high loads only once.
- R5: A reload overrides the decrement. The count never wraps below zero, and a length of 0 holds the count at 0.
- R6: Each zero event turns the out-of-sync indicator on for exactly LED_CYCLES cycles, beginning one clock after the zero cycle. A new zero event restarts that window at its full width.
- R7: Each detected sync edge turns the sync-present indicator on for exactly LED_CYCLES cycles. A new sync edge restarts that window at its full width.
- R8: The pulse count rises by one for each detected sync edge. It wraps from all ones to zero and raises no flag.
- R9: While the clear input is high the pulse count is forced to zero, even when a sync edge arrives in the same cycle. Reset also clears it.
- R10: After reset the timer stays idle at 0 and raises no zero event until its first reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous core reset |
| sync_async_i | input | 1 | External sync input, asynchronous to clk |
| host_ctrl_i | input | CNT_W+1 | Start request in the top bit, cycle length below it |
| pcnt_clr_i | input | 1 | Level that holds the sync pulse count at zero |
| count_o | output | CNT_W | Live macrocycle count |
| pcnt_o | output | PCNT_W | Number of detected sync edges |
| late_led_o | output | 1 | Stretched out-of-sync indicator |
| sync_led_o | output | 1 | Stretched sync-present indicator |

## Verification
The bench builds the block with CNT_W=8, PCNT_W=4, LED_CYCLES=20 and two sync stages. The 8-bit length lets the maximum cycle run longer than an indicator window, so the out-of-sync indicator can be watched both switching on and going dark. The 20-cycle window makes the exact indicator width and its restart checkable within a few dozen clocks. The 4-bit pulse count reaches its wrap to zero after sixteen sync edges.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    // Default widths and indicator length for the macrocycle timer
    localparam int unsigned MCYC_CNT_W       = 31;
    localparam int unsigned MCYC_PCNT_W      = 32;
    localparam int unsigned MCYC_LED_CYCLES  = 1_000_000;
    localparam int unsigned MCYC_SYNC_STAGES = 2;

    // External restart requests seen by the down-counter
    typedef struct packed {
        logic host;
        logic sync;
    } restart_t;

endpackage

// File: rtl/mcyc_edge_detect.sv
module mcyc_edge_detect #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o
);

    localparam int unsigned SH_W = STAGES + 1;

    logic [SH_W-1:0] sh_d;
    logic [SH_W-1:0] sh_q;
    logic            cur;

    generate
        if (STAGES == 0) begin : g_direct
            // synchronous level: edge detect only
            assign cur  = level_i;
            assign sh_d = level_i;
        end else begin : g_sync
            assign cur  = sh_q[STAGES-1];
            assign sh_d = {sh_q[STAGES-1:0], level_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign pulse_o = cur & ~sh_q[STAGES];

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o); // R2

endmodule

// File: rtl/mcyc_down_timer.sv
module mcyc_down_timer
    import mcyc_pkg::*;
#(
    parameter int unsigned CNT_W = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] length_i,
    input  restart_t         restart_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_p_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } tmr_t;

    tmr_t st_d;
    tmr_t st_q;
    logic reload;

    always_comb begin
        st_d     = st_q;
        zero_p_o = st_q.run && (st_q.cnt == '0);
        reload   = zero_p_o | restart_i.host | restart_i.sync;
        if (reload) begin
            st_d.cnt = length_i;
            st_d.run = 1'b1;
        end else if (st_q.run) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.cnt;

    AST_RESTART_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i.host || restart_i.sync) |=> count_o == $past(length_i)); // R4
    AST_ZERO_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        zero_p_o |=> count_o == $past(length_i)); // R5
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != '0 && !restart_i.host && !restart_i.sync)
        |=> count_o == $past(count_o) - 1'b1); // R3
    AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_p_o && count_o == '0 && !restart_i.host && !restart_i.sync)
        |=> count_o == '0); // R10

endmodule

// File: rtl/mcyc_stretch.sv
module mcyc_stretch #(
    parameter int unsigned WIDTH = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic led_o
);

    localparam int unsigned CW = $clog2(WIDTH + 1);

    logic [CW-1:0] left_d;
    logic [CW-1:0] left_q;

    always_comb begin
        left_d = left_q;
        if (trig_i)              left_d = CW'(WIDTH);
        else if (left_q != '0)   left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign led_o = (left_q != '0);

    AST_STRETCH_ON: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> led_o); // R6
    AST_STRETCH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> left_q == CW'(WIDTH)); // R7

endmodule

// File: rtl/mcyc_pulse_count.sv
module mcyc_pulse_count #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] count_o
);

    logic [W-1:0] cnt_d;
    logic [W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + 1'b1; // wraps silently
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> count_o == '0); // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> count_o == $past(count_o) + 1'b1); // R8
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !clr_i) |=> $stable(count_o)); // R8

endmodule

// File: rtl/mcyc_sync_timer.sv
module mcyc_sync_timer
    import mcyc_pkg::*;
#(
    parameter int unsigned CNT_W       = MCYC_CNT_W,
    parameter int unsigned PCNT_W      = MCYC_PCNT_W,
    parameter int unsigned LED_CYCLES  = MCYC_LED_CYCLES,
    parameter int unsigned SYNC_STAGES = MCYC_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_async_i,
    input  logic [CNT_W:0]    host_ctrl_i,
    input  logic              pcnt_clr_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [PCNT_W-1:0] pcnt_o,
    output logic              late_led_o,
    output logic              sync_led_o
);

    localparam int unsigned START_BIT = CNT_W;

    logic     sync_p;
    logic     start_p;
    logic     zero_p;
    restart_t restart;

    mcyc_edge_detect #(.STAGES(SYNC_STAGES)) i_sync_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_async_i),
        .pulse_o (sync_p)
    );

    mcyc_edge_detect #(.STAGES(0)) i_start_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (host_ctrl_i[START_BIT]),
        .pulse_o (start_p)
    );

    assign restart.host = start_p;
    assign restart.sync = sync_p;

    mcyc_down_timer #(.CNT_W(CNT_W)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .length_i  (host_ctrl_i[CNT_W-1:0]),
        .restart_i (restart),
        .count_o   (count_o),
        .zero_p_o  (zero_p)
    );

    mcyc_stretch #(.WIDTH(LED_CYCLES)) i_late_led (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (zero_p),
        .led_o  (late_led_o)
    );

    mcyc_stretch #(.WIDTH(LED_CYCLES)) i_sync_led (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (sync_p),
        .led_o  (sync_led_o)
    );

    mcyc_pulse_count #(.W(PCNT_W)) i_pcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (sync_p),
        .clr_i   (pcnt_clr_i),
        .count_o (pcnt_o)
    );

    AST_START_HELD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> !start_p); // R4

endmodule

// File: tb/test_mcyc_sync_timer.sv
module test_mcyc_sync_timer;

    localparam int unsigned CNT_W  = 8;
    localparam int unsigned PCNT_W = 4;
    localparam int unsigned LEDW   = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sync_async_i = 1'b0;
    logic [CNT_W:0]    host_ctrl_i = '0;
    logic              pcnt_clr_i = 1'b0;
    logic [CNT_W-1:0]  count_o;
    logic [PCNT_W-1:0] pcnt_o;
    logic              late_led_o;
    logic              sync_led_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mcyc_sync_timer #(
        .CNT_W(CNT_W), .PCNT_W(PCNT_W), .LED_CYCLES(LEDW), .SYNC_STAGES(2)
    ) i_mcyc_sync_timer (
        .clk(clk), .rst_n(rst_n), .sync_async_i(sync_async_i),
        .host_ctrl_i(host_ctrl_i), .pcnt_clr_i(pcnt_clr_i),
        .count_o(count_o), .pcnt_o(pcnt_o),
        .late_led_o(late_led_o), .sync_led_o(sync_led_o)
    );

    // {length, cycles to wait after the load, expected count}
    localparam logic [23:0] VEC [4] = '{
        {8'd0,   8'd6, 8'd0},
        {8'd10,  8'd4, 8'd6},
        {8'd3,   8'd5, 8'd2},
        {8'd255, 8'd7, 8'd248}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // raise sync and wait until its detection has reached the outputs
    task automatic sync_rise();
        sync_async_i = 1'b1;
        edges(3);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        // reset state
        edges(3);
        chk("R1 count in reset", 32'(count_o), 0);
        chk("R1 pcnt in reset", 32'(pcnt_o), 0);
        chk("R1 leds in reset", {30'd0, late_led_o, sync_led_o}, 0);
        rst_n = 1'b1;
        edges(10);
        chk("R10 idle count", 32'(count_o), 0);
        chk("R10 no late led while idle", 32'(late_led_o), 0);

        // table of host-start reloads: R3 R4 R5
        for (int i = 0; i < 4; i++) begin
            host_ctrl_i = {1'b1, VEC[i][23:16]};
            edges(1);
            chk("R4 start loads length", 32'(count_o), 32'(VEC[i][23:16]));
            host_ctrl_i[CNT_W] = 1'b0;
            edges(int'(VEC[i][15:8]));
            chk("R3 R5 count after run", 32'(count_o), 32'(VEC[i][7:0]));
        end

        // held start loads once
        host_ctrl_i = {1'b1, 8'd200};
        edges(1);
        chk("R4 load 200", 32'(count_o), 200);
        edges(3);
        chk("R4 held start no reload", 32'(count_o), 197);
        host_ctrl_i[CNT_W] = 1'b0;
        edges(30);
        chk("R3 long run", 32'(count_o), 167);
        chk("R6 late led dark", 32'(late_led_o), 0);
        chk("R7 sync led dark", 32'(sync_led_o), 0);

        // sync edge restarts and counts
        host_ctrl_i = {1'b0, 8'd100};
        sync_rise();
        chk("R4 sync loads length", 32'(count_o), 100);
        chk("R8 pcnt first", 32'(pcnt_o), 1);
        chk("R7 sync led on", 32'(sync_led_o), 1);
        edges(5);
        chk("R2 held sync single", 32'(pcnt_o), 1);
        chk("R2 held sync no reload", 32'(count_o), 95);
        sync_async_i = 1'b0;
        edges(14);
        chk("R7 sync led last cycle", 32'(sync_led_o), 1);
        edges(1);
        chk("R7 sync led off", 32'(sync_led_o), 0);

        // sync led retrigger
        sync_rise();
        sync_async_i = 1'b0;
        edges(10);
        sync_rise();
        sync_async_i = 1'b0;
        edges(15);
        chk("R7 retrigger extends", 32'(sync_led_o), 1);
        chk("R8 pcnt three", 32'(pcnt_o), 3);

        // late detection
        host_ctrl_i = {1'b1, 8'd4};
        edges(1);
        chk("R4 load 4", 32'(count_o), 4);
        host_ctrl_i[CNT_W] = 1'b0;
        edges(4);
        chk("R3 reached zero", 32'(count_o), 0);
        chk("R6 late not yet", 32'(late_led_o), 0);
        edges(1);
        chk("R5 zero reloads", 32'(count_o), 4);
        chk("R6 late on", 32'(late_led_o), 1);
        host_ctrl_i = {1'b1, 8'd255};
        edges(1);
        host_ctrl_i[CNT_W] = 1'b0;
        edges(18);
        chk("R6 late last cycle", 32'(late_led_o), 1);
        edges(1);
        chk("R6 late off", 32'(late_led_o), 0);

        // wrap of pulse count
        for (int i = 0; i < 13; i++) begin
            sync_rise();
            sync_async_i = 1'b0;
            edges(2);
        end
        chk("R8 wrap to zero", 32'(pcnt_o), 0);

        // clear
        sync_rise();
        sync_async_i = 1'b0;
        edges(2);
        chk("R8 count after wrap", 32'(pcnt_o), 1);
        pcnt_clr_i = 1'b1;
        sync_rise();
        chk("R9 clear beats sync", 32'(pcnt_o), 0);
        pcnt_clr_i = 1'b0;
        sync_async_i = 1'b0;
        edges(3);
        chk("R9 stays cleared", 32'(pcnt_o), 0);
        sync_rise();
        sync_async_i = 1'b0;
        chk("R8 count after clear", 32'(pcnt_o), 1);
        rst_n = 1'b0;
        edges(1);
        chk("R9 reset clears pcnt", 32'(pcnt_o), 0);
        chk("R1 reset clears count", 32'(count_o), 0);
        chk("R1 reset clears leds", {30'd0, late_led_o, sync_led_o}, 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule